// File: doc/BRIEF.md
# Mersenne Twister Pseudorandom Word Generator

This block produces a stream of 32-bit pseudorandom words using the 624-word twisted generalised feedback shift register known as MT19937. A 624-word state table is kept on chip. When a new 32-bit seed arrives on a one-cycle load strobe, the block expands it into the full table, one word per cycle. After that it hands out one tempered word per valid/ready transfer.

Each transfer renews a single state word in place. The block reads the current word, its successor and the word 397 places ahead, all modulo 624. It splices the top bit of the current word with the low 31 bits of its successor. The splice is shifted right by one and, when its low bit was set, XORed with 0x9908B0DF. The result is XORed with the far word and written back over the current word. The renewed word then goes through four shift/mask/XOR tempering steps to give the output. With the consumer always ready, the block delivers one word per clock.

Top module: `mt_prng_core`

## Requirements
- R1: While reset is held, out_valid is low. Leaving reset seeds the table with 5489, so the first word delivered after reset is 3499211612 (decimal).
- R2: Seeding writes table word 0 with the seed. For i from 1 to 623 it writes p_i = 1812433253 × (p_{i-1} XOR (p_{i-1} >> 30)) + i, modulo 2^32. The first word delivered after any load matches this table.
- R3: out_valid is low for exactly 624 cycles after reset release, and for exactly 624 cycles after the cycle in which seed_load is sampled high. It is high in the following cycle unless another load occurs.
- R4: In any cycle with seed_load high, out_valid is low and no transfer takes place, even if out_ready is high. The words that follow come from the new seed, starting at its first word.
- R5: While out_valid is high and out_ready is low, out_data holds its value and the sequence does not advance.
- R6: Each transfer replaces table word k with x[k+397] XOR twist({x[k] bit 31, x[k+1] bits 30..0}). Indices are taken mod 624, and the pointer k steps mod 624. twist(v) = v >> 1, XORed with 0x9908B0DF when v bit 0 is 1. The stream stays correct across many wraps of the pointer.
- R7: out_data is the renewed word after these steps, in order: y ^= y>>11; y ^= (y<<7) & 0x9D2C5680; y ^= (y<<15) & 0xEFC60000; y ^= y>>18.
- R8: With out_ready held high and no load, a new word is transferred on every clock.
- R9: A load that arrives while seeding is still in progress restarts seeding from the new seed. The 624-cycle wait and the resulting sequence are then those of the new seed alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; applies the default seed |
| seed_load | input | 1 | One-cycle strobe that starts seeding from seed_value |
| seed_value | input | 32 | Seed sampled when seed_load is high |
| out_valid | output | 1 | A generated word is available on out_data |
| out_ready | input | 1 | Consumer accepts out_data in this cycle |
| out_data | output | 32 | Tempered pseudorandom word |

## Verification
A seed load and an output transfer can be requested in the same cycle. The bench provokes this by raising seed_load while out_ready is high and the stream is running. It also loads again while an earlier seeding pass is still in progress. In both cases the bench checks three things: out_valid drops in that very cycle, the wait before the next word is counted afresh, and the next words match a reference generator re-seeded at that point. That reference regenerates its whole table in bulk, not word by word as the RTL does.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int MT_W     = 32;
  localparam int LOW_BITS = 31;

  typedef logic [MT_W-1:0] mt_word_t;

  localparam mt_word_t TWIST_XOR  = 32'h9908B0DF;
  localparam mt_word_t TEMPER_B   = 32'h9D2C5680;
  localparam mt_word_t TEMPER_C   = 32'hEFC60000;
  localparam mt_word_t SEED_MULT  = 32'd1812433253;

  // Renew one state word from the current, next and far words.
  function automatic mt_word_t mt_splice_twist(mt_word_t cur, mt_word_t nxt, mt_word_t far);
    mt_word_t sp;
    sp = {cur[MT_W-1:LOW_BITS], nxt[LOW_BITS-1:0]};
    return far ^ (sp >> 1) ^ (sp[0] ? TWIST_XOR : '0);
  endfunction

  // Four-step output tempering.
  function automatic mt_word_t mt_temper(mt_word_t x);
    mt_word_t y;
    y = x ^ (x >> 11);
    y = y ^ ((y << 7) & TEMPER_B);
    y = y ^ ((y << 15) & TEMPER_C);
    return y ^ (y >> 18);
  endfunction

  // Seed expansion step for table index idx.
  function automatic mt_word_t mt_seed_step(mt_word_t prev, mt_word_t idx);
    mt_word_t mix;
    mix = prev ^ (prev >> 30);
    return mt_word_t'(SEED_MULT * mix) + idx;
  endfunction
endpackage

// File: rtl/mt_state_mem.sv
module mt_state_mem
  import mt_pkg::*;
#(
  parameter int DEPTH    = 624,
  parameter int RD_PORTS = 3,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  mt_word_t                      wdata,
  input  logic [RD_PORTS-1:0][AW-1:0]   raddr,
  output logic [RD_PORTS-1:0][MT_W-1:0] rdata
);
  mt_word_t table_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) table_q[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p] = table_q[raddr[p]];
  end
endmodule

// File: rtl/mt_seed_seq.sv
module mt_seed_seq
  import mt_pkg::*;
#(
  parameter int       DEPTH        = 624,
  parameter mt_word_t SEED_DEFAULT = 32'd5489,
  localparam int      AW           = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  mt_word_t      load_value,
  output logic          busy,
  output logic [AW-1:0] wr_addr,
  output mt_word_t      wr_data
);
  logic [AW-1:0] idx_q;
  mt_word_t      prev_q;

  assign wr_addr = idx_q;
  assign wr_data = (idx_q == '0) ? prev_q : mt_seed_step(prev_q, mt_word_t'(idx_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      prev_q <= SEED_DEFAULT;
    end else if (load) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      prev_q <= load_value;
    end else if (busy) begin
      prev_q <= wr_data;
      if (idx_q == AW'(DEPTH-1)) busy  <= 1'b0;
      else                       idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_twist_ptr.sv
module mt_twist_ptr #(
  parameter int  DEPTH = 624,
  parameter int  MID   = 397,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_next,
  output logic [AW-1:0] ptr_mid
);
  localparam int WRAP_AT = DEPTH - MID;

  assign ptr_next = (ptr == AW'(DEPTH-1)) ? '0 : ptr + 1'b1;
  assign ptr_mid  = (ptr >= AW'(WRAP_AT)) ? ptr - AW'(WRAP_AT) : ptr + AW'(MID);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (clear)   ptr <= '0;
    else if (advance) ptr <= ptr_next;
  end
endmodule

// File: rtl/mt_prng_core.sv
module mt_prng_core
  import mt_pkg::*;
#(
  parameter int       STATE_N      = 624,
  parameter int       MID_M        = 397,
  parameter mt_word_t SEED_DEFAULT = 32'd5489,
  localparam int      AW           = $clog2(STATE_N)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load,
  input  logic [31:0] seed_value,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);
  logic                  seed_busy;
  logic [AW-1:0]         seed_addr;
  mt_word_t              seed_word;
  logic [AW-1:0]         twist_ptr, twist_ptr_next, twist_ptr_mid;
  logic [2:0][AW-1:0]    rd_addr;
  logic [2:0][MT_W-1:0]  rd_data;
  mt_word_t              renewed_word;
  logic                  twist_fire;
  logic                  mem_we;
  logic [AW-1:0]         mem_waddr;
  mt_word_t              mem_wdata;

  mt_seed_seq #(.DEPTH(STATE_N), .SEED_DEFAULT(SEED_DEFAULT)) u_seed (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .load_value(seed_value),
    .busy(seed_busy), .wr_addr(seed_addr), .wr_data(seed_word)
  );

  mt_twist_ptr #(.DEPTH(STATE_N), .MID(MID_M)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(seed_load), .advance(twist_fire),
    .ptr(twist_ptr), .ptr_next(twist_ptr_next), .ptr_mid(twist_ptr_mid)
  );

  assign rd_addr = {twist_ptr_mid, twist_ptr_next, twist_ptr};

  mt_state_mem #(.DEPTH(STATE_N), .RD_PORTS(3)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign renewed_word = mt_splice_twist(rd_data[0], rd_data[1], rd_data[2]);
  assign out_data     = mt_temper(renewed_word);
  assign out_valid    = !seed_busy && !seed_load;
  assign twist_fire   = out_valid && out_ready;

  assign mem_we    = seed_busy || twist_fire;
  assign mem_waddr = seed_busy ? seed_addr : twist_ptr;
  assign mem_wdata = seed_busy ? seed_word : renewed_word;
endmodule

// File: rtl/mt_prng_checker.sv
module mt_prng_checker #(
  parameter int  DEPTH = 624,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seed_load,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic          seed_busy,
  input logic          mem_we,
  input logic [AW-1:0] twist_ptr
);
  logic [AW:0] since_load;

  always_ff @(posedge clk) begin
    if (!rst_n || seed_load)               since_load <= '0;
    else if (since_load < (AW+1)'(DEPTH))  since_load <= since_load + 1'b1;
  end

  a_r3_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |-> (out_valid == (since_load == (AW+1)'(DEPTH))));

  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    seed_busy |-> !out_valid);

  a_r4_load_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |-> !out_valid);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (seed_load || $stable(out_data)));

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=>
      (twist_ptr == (($past(twist_ptr) == AW'(DEPTH-1)) ? '0 : $past(twist_ptr) + 1'b1)));

  a_r6_write_source: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (seed_busy || (out_valid && out_ready)));
endmodule

bind mt_prng_core mt_prng_checker #(.DEPTH(STATE_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .seed_busy(seed_busy),
  .mem_we(mem_we), .twist_ptr(twist_ptr)
);

// File: tb/mt_prng_core_tb.sv
module mt_prng_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        seed_load;
  logic [31:0] seed_value;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  mt_prng_core dut_i (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  int    since  = 0;
  int    nout   = 0;
  bit    first_out;
  bit    want_known;
  bit    prev_stall;
  string first_tag = "R2";
  logic [31:0] prev_data;
  logic [31:0] ref_mt [624];
  int    ref_pos;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_seed(logic [31:0] s);
    ref_mt[0] = s;
    for (int i = 1; i < 624; i++)
      ref_mt[i] = 32'd1812433253 * (ref_mt[i-1] ^ {30'd0, ref_mt[i-1][31:30]}) + i;
    ref_pos = 624;
  endfunction

  function automatic logic [31:0] ref_draw();
    logic [31:0] y;
    if (ref_pos >= 624) begin
      for (int j = 0; j < 624; j++) begin
        y = {ref_mt[j][31], ref_mt[(j + 1) % 624][30:0]};
        ref_mt[j] = ref_mt[(j + 397) % 624] ^ {1'b0, y[31:1]};
        if (y[0]) ref_mt[j] = ref_mt[j] ^ 32'h9908B0DF;
      end
      ref_pos = 0;
    end
    y = ref_mt[ref_pos];
    ref_pos++;
    y = y ^ {11'd0, y[31:11]};
    y = y ^ ({y[24:0], 7'd0} & 32'h9D2C5680);
    y = y ^ ({y[16:0], 15'd0} & 32'hEFC60000);
    y = y ^ {18'd0, y[31:18]};
    return y;
  endfunction

  task automatic cyc(bit rdy, bit ld, logic [31:0] sv);
    logic [31:0] exp;
    @(negedge clk);
    out_ready  = rdy;
    seed_load  = ld;
    seed_value = sv;
    #1;
    if (ld) begin
      chk(out_valid == 1'b0, "R4", {31'd0, out_valid}, 32'd0);
      first_tag  = (since < 624) ? "R9" : "R2";
      ref_seed(sv);
      since      = 0;
      first_out  = 1'b1;
      prev_stall = 1'b0;
    end else begin
      chk(out_valid == (since == 624), "R3", {31'd0, out_valid}, {31'd0, since == 624});
      if (prev_stall && out_valid)
        chk(out_data == prev_data, "R5", out_data, prev_data);
      if (out_valid && rdy) begin
        exp = ref_draw();
        chk(out_data == exp, first_out ? first_tag : "R6/R7", out_data, exp);
        if (want_known) begin
          chk(out_data == 32'd3499211612, "R1", out_data, 32'd3499211612);
          want_known = 1'b0;
        end
        first_out = 1'b0;
        nout++;
      end
      prev_stall = out_valid && !rdy;
      prev_data  = out_data;
      if (since < 624) since++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1103));
    rst_n = 1'b0; seed_load = 1'b0; seed_value = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    since = 1; ref_seed(32'd5489); first_out = 1'b1; first_tag = "R2";
    want_known = 1'b1; prev_stall = 1'b0;

    // Default seed, continuous ready, wraps the pointer twice (R6, R8)
    repeat (624) cyc(1'b1, 1'b0, 32'd0);
    repeat (1400) cyc(1'b1, 1'b0, 32'd0);
    chk(nout == 1401, "R8", nout, 1401);

    // Random back-pressure (R5)
    repeat (800) cyc(1'($urandom_range(0, 1)), 1'b0, 32'd0);

    // Load while running with ready high (R4)
    cyc(1'b1, 1'b1, $urandom);
    repeat (900) cyc(1'($urandom_range(0, 1)), 1'b0, 32'd0);

    // Load during seeding (R9)
    cyc(1'b1, 1'b1, $urandom);
    repeat (100) cyc(1'b1, 1'b0, 32'd0);
    cyc(1'b1, 1'b1, $urandom);
    repeat (700) cyc(1'b1, 1'b0, 32'd0);

    // Extreme seeds with ready low on the load cycle
    cyc(1'b0, 1'b1, 32'd0);
    repeat (700) cyc(1'($urandom_range(0, 1)), 1'b0, 32'd0);
    cyc(1'b0, 1'b1, 32'hFFFFFFFF);
    repeat (700) cyc(1'($urandom_range(0, 1)), 1'b0, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule